// File: doc/BRIEF.md
# Serial Address Recognition Filter

This block sits between the frame assembler of a serial receiver and the receive-complete flag. Each time the receiver reports a finished frame, the filter decides whether the frame may raise the receive flag. When hardware address recognition is switched on, a frame raises the flag only if it is an address frame for this station. That lets a controller on a multidrop line skip data frames meant for other stations. The way a frame qualifies depends on the operating mode. In the nine-bit modes the extra ninth bit qualifies the frame. In the eight-bit mode the stop bit qualifies it. In shift mode the filter stands aside entirely.

The station is described by an address value and a mask. A mask bit of 0 marks that address position as don't-care. The filter derives two comparisons from these: a "given" address and a "broadcast" address. A frame is accepted when it matches either one.

The decision is sampled on the clock edge that sees the frame-complete strobe and appears one cycle later as a single-cycle pulse. The two match indicators appear in that same cycle. Nothing is remembered from one frame to the next.

Top module: `rx_addr_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, rx_flag_o, given_hit_o and bcast_hit_o are 0.
- R2: In modes 1, 2 and 3 with recog_en_i = 0, every completed frame raises rx_flag_o. The ninth bit, the stop-bit indication and the byte value do not matter.
- R3: In mode 0 (mode_i = 2'b00, shift mode), recog_en_i has no effect and every completed frame raises rx_flag_o.
- R4: In mode 2 or 3 (mode_i[1] = 1, nine-bit modes) with recog_en_i = 1, rx_flag_o is raised only when rx_bit9_i = 1 (address frame) and the byte gives a given or broadcast match. A frame with rx_bit9_i = 0 (data frame) never raises it.
- R5: In mode 1 (mode_i = 2'b01, eight-bit mode) with recog_en_i = 1, rx_flag_o is raised only when stop_ok_i = 1 and the byte gives a given or broadcast match.
- R6: A given match occurs when the byte equals station_addr_i at every bit position where addr_mask_i is 1.
- R7: A broadcast match occurs when the byte has a 1 at every position where (station_addr_i | addr_mask_i) is 1. If that OR is all zeros, every byte matches as broadcast.
- R8: All outputs are single-cycle pulses in the cycle after frame_done_i is sampled high. They are 0 in a cycle that follows no strobe. Back-to-back strobes each give an independent result.
- R9: given_hit_o and bcast_hit_o report the R6 and R7 comparisons for every completed frame, whatever the mode and recog_en_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_done_i | input | 1 | One-cycle strobe: a received frame is complete |
| rx_byte_i | input | DATA_W | Received data byte |
| rx_bit9_i | input | 1 | Received ninth bit (1 = address, 0 = data) |
| stop_ok_i | input | 1 | Received stop bit was valid |
| mode_i | input | 2 | Operating mode: 0 shift, 1 eight-bit, 2 and 3 nine-bit |
| recog_en_i | input | 1 | Address recognition enable |
| station_addr_i | input | DATA_W | Station address value |
| addr_mask_i | input | DATA_W | Address mask; a 0 bit is don't-care |
| rx_flag_o | output | 1 | Pulse: frame may raise the receive flag |
| given_hit_o | output | 1 | Pulse: frame matched the given address |
| bcast_hit_o | output | 1 | Pulse: frame matched the broadcast address |

## Verification
The only state in the block is one output register stage. A wrong decision therefore shows at the ports exactly one cycle after the strobe that caused it, as a missing or extra pulse. A stuck register shows as a pulse in a cycle that follows no strobe. A wrong bit in either comparator shows as a wrong match indicator on the first frame whose byte, address and mask exercise that bit. For this reason the bench mixes directed patterns with many varied bytes and masks. A mode decode error shows as a flag that ignores the ninth bit or the stop bit in the wrong mode.

// File: rtl/rx_addr_pkg.sv
package rx_addr_pkg;

   typedef enum logic [1:0] {
      MODE_SHIFT  = 2'd0,
      MODE_UART8  = 2'd1,
      MODE_UART9A = 2'd2,
      MODE_UART9B = 2'd3
   } rx_mode_e;

   function automatic logic mode_is_nine(input rx_mode_e m);
      return (m == MODE_UART9A) || (m == MODE_UART9B);
   endfunction

   typedef struct packed {
      logic flag;
      logic given;
      logic bcast;
   } rx_verdict_t;

endpackage

// File: rtl/rx_addr_match.sv
module rx_addr_match #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] byte_i,
   input  logic [DATA_W-1:0] addr_i,
   input  logic [DATA_W-1:0] mask_i,
   output logic              given_o,
   output logic              bcast_o
);
   logic [DATA_W-1:0] bc_addr;
   logic [DATA_W-1:0] given_ok;
   logic [DATA_W-1:0] bcast_ok;

   assign bc_addr = addr_i | mask_i;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      // masked-off bit is don't-care; otherwise the byte must agree with the address
      assign given_ok[i] = ~mask_i[i] | (byte_i[i] ~^ addr_i[i]);
      // broadcast: a bit set in the OR must be set in the byte
      assign bcast_ok[i] = ~bc_addr[i] | byte_i[i];
   end

   assign given_o = &given_ok;
   assign bcast_o = &bcast_ok;
endmodule

// File: rtl/rx_addr_qual.sv
module rx_addr_qual
   import rx_addr_pkg::*;
(
   input  rx_mode_e mode_i,
   input  logic     recog_en_i,
   input  logic     bit9_i,
   input  logic     stop_ok_i,
   input  logic     hit_i,
   output logic     accept_o
);
   logic qualifier;

   always_comb begin
      qualifier = 1'b0;
      accept_o  = 1'b1;
      unique case (mode_i)
         MODE_SHIFT:  qualifier = 1'b1;
         MODE_UART8:  qualifier = stop_ok_i;
         default:     qualifier = bit9_i;
      endcase
      if (mode_i != MODE_SHIFT && recog_en_i)
         accept_o = qualifier & hit_i;
   end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import rx_addr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_done_i,
   input  logic [DATA_W-1:0] rx_byte_i,
   input  logic              rx_bit9_i,
   input  logic              stop_ok_i,
   input  logic [1:0]        mode_i,
   input  logic              recog_en_i,
   input  logic [DATA_W-1:0] station_addr_i,
   input  logic [DATA_W-1:0] addr_mask_i,
   output logic              rx_flag_o,
   output logic              given_hit_o,
   output logic              bcast_hit_o
);
   localparam int MIN_W = 2;
   localparam int MAX_W = 32;

   if (DATA_W < MIN_W || DATA_W > MAX_W) begin : g_bad_width
      $error("rx_addr_filter: DATA_W out of supported range");
   end

   rx_mode_e    mode;
   logic        given_hit;
   logic        bcast_hit;
   logic        accept;
   rx_verdict_t next_v;
   rx_verdict_t cur_v;

   assign mode = rx_mode_e'(mode_i);

   rx_addr_match #(.DATA_W(DATA_W)) u_match (
      .byte_i  (rx_byte_i),
      .addr_i  (station_addr_i),
      .mask_i  (addr_mask_i),
      .given_o (given_hit),
      .bcast_o (bcast_hit)
   );

   rx_addr_qual u_qual (
      .mode_i     (mode),
      .recog_en_i (recog_en_i),
      .bit9_i     (rx_bit9_i),
      .stop_ok_i  (stop_ok_i),
      .hit_i      (given_hit | bcast_hit),
      .accept_o   (accept)
   );

   always_comb begin
      next_v.flag  = frame_done_i & accept;
      next_v.given = frame_done_i & given_hit;
      next_v.bcast = frame_done_i & bcast_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_v <= '0;
      else        cur_v <= next_v;
   end

   assign rx_flag_o   = cur_v.flag;
   assign given_hit_o = cur_v.given;
   assign bcast_hit_o = cur_v.bcast;
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_done_i,
   input logic [DATA_W-1:0] rx_byte_i,
   input logic              rx_bit9_i,
   input logic              stop_ok_i,
   input logic [1:0]        mode_i,
   input logic              recog_en_i,
   input logic [DATA_W-1:0] station_addr_i,
   input logic [DATA_W-1:0] addr_mask_i,
   input logic              rx_flag_o,
   input logic              given_hit_o,
   input logic              bcast_hit_o
);
   logic g_ref, b_ref;
   assign g_ref = ((rx_byte_i ^ station_addr_i) & addr_mask_i) == '0;
   assign b_ref = ((station_addr_i | addr_mask_i) & ~rx_byte_i) == '0;

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> !rx_flag_o && !given_hit_o && !bcast_hit_o);

   a_r2_disabled_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done_i && !recog_en_i) |=> rx_flag_o);

   a_r3_shift_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done_i && mode_i == 2'd0) |=> rx_flag_o);

   a_r4_data_frame_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done_i && recog_en_i && mode_i[1] && !rx_bit9_i) |=> !rx_flag_o);

   a_r4_addr_hit_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done_i && recog_en_i && mode_i[1] && rx_bit9_i && (g_ref || b_ref)) |=> rx_flag_o);

   a_r5_bad_stop_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done_i && recog_en_i && mode_i == 2'd1 && !stop_ok_i) |=> !rx_flag_o);

   a_r6_given_hit: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done_i |=> (given_hit_o == $past(g_ref)));

   a_r7_bcast_hit: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done_i |=> (bcast_hit_o == $past(b_ref)));

   a_r8_no_strobe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_done_i |=> !rx_flag_o && !given_hit_o && !bcast_hit_o);
endmodule

bind rx_addr_filter rx_addr_filter_chk #(.DATA_W(DATA_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .frame_done_i   (frame_done_i),
   .rx_byte_i      (rx_byte_i),
   .rx_bit9_i      (rx_bit9_i),
   .stop_ok_i      (stop_ok_i),
   .mode_i         (mode_i),
   .recog_en_i     (recog_en_i),
   .station_addr_i (station_addr_i),
   .addr_mask_i    (addr_mask_i),
   .rx_flag_o      (rx_flag_o),
   .given_hit_o    (given_hit_o),
   .bcast_hit_o    (bcast_hit_o)
);

// File: tb/tb_rx_addr_filter.sv
module tb_rx_addr_filter;
   localparam int CLK_P  = 10;
   localparam int W      = 8;
   localparam int WD_MAX = 20000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         frame_done = 1'b0;
   logic [W-1:0] rx_byte = '0;
   logic         bit9 = 1'b0;
   logic         stop_ok = 1'b0;
   logic [1:0]   mode = 2'd0;
   logic         recog = 1'b0;
   logic [W-1:0] saddr = '0;
   logic [W-1:0] smask = '0;
   logic         flag, ghit, bhit;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   bit mon_on = 1'b0;

   logic [2:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_P/2) clk = ~clk;

   rx_addr_filter #(.DATA_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .frame_done_i(frame_done),
      .rx_byte_i(rx_byte), .rx_bit9_i(bit9), .stop_ok_i(stop_ok),
      .mode_i(mode), .recog_en_i(recog), .station_addr_i(saddr),
      .addr_mask_i(smask), .rx_flag_o(flag), .given_hit_o(ghit),
      .bcast_hit_o(bhit));

   task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: flag/given/bcast actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // driver: presents one frame and pushes the result expected from the requirements
   task automatic send(input logic [W-1:0] b, input logic n9, input logic st,
                       input logic [1:0] m, input logic en,
                       input logic [W-1:0] sa, input logic [W-1:0] mk,
                       input bit hold, input string tag);
      logic g, bc, f;
      @(negedge clk);
      rx_byte = b; bit9 = n9; stop_ok = st; mode = m; recog = en;
      saddr = sa; smask = mk; frame_done = 1'b1;
      g  = 1'b1;
      bc = 1'b1;
      for (int i = 0; i < W; i++) begin
         if (mk[i] && b[i] != sa[i]) g = 1'b0;
         if ((sa[i] || mk[i]) && !b[i]) bc = 1'b0;
      end
      if (m == 2'd0 || !en)  f = 1'b1;
      else if (m == 2'd1)    f = st && (g || bc);
      else                   f = n9 && (g || bc);
      exp_q.push_back({f, g, bc});
      tag_q.push_back(tag);
      if (!hold) begin
         @(negedge clk);
         frame_done = 1'b0;
      end
   endtask

   // monitor: pops one expected item per sampled strobe, else expects silence (R8)
   always @(posedge clk) begin
      logic seen;
      seen = frame_done;
      #(CLK_P/4);
      if (mon_on) begin
         if (seen) begin
            if (exp_q.size() == 0) check("R8 queue", 3'b111, 3'b000);
            else check(tag_q.pop_front(), {flag, ghit, bhit}, exp_q.pop_front());
         end else begin
            check("R8 idle", {flag, ghit, bhit}, 3'b000);
         end
      end
   end

   initial begin : watchdog
      for (int c = 0; c < WD_MAX; c++) begin
         @(posedge clk);
         if (done) disable watchdog;
      end
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 in reset", {flag, ghit, bhit}, 3'b000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", {flag, ghit, bhit}, 3'b000);
      mon_on = 1'b1;

      // R2: recognition off passes anything
      send(8'h00, 1'b0, 1'b0, 2'd2, 1'b0, 8'h5A, 8'hFF, 0, "R2 nine-bit data");
      send(8'h13, 1'b0, 1'b0, 2'd1, 1'b0, 8'h5A, 8'hFF, 0, "R2 eight-bit bad stop");
      // R3: shift mode ignores enable
      send(8'h01, 1'b0, 1'b0, 2'd0, 1'b1, 8'h5A, 8'hFF, 0, "R3 shift mode");
      // R4: nine-bit filtering
      send(8'h5A, 1'b1, 1'b1, 2'd2, 1'b1, 8'h5A, 8'hFF, 0, "R4 exact address");
      send(8'h5A, 1'b0, 1'b1, 2'd3, 1'b1, 8'h5A, 8'hFF, 0, "R4 data frame");
      send(8'h5B, 1'b1, 1'b1, 2'd3, 1'b1, 8'h5A, 8'hFF, 0, "R4 wrong address");
      send(8'hFF, 1'b1, 1'b0, 2'd2, 1'b1, 8'h5A, 8'hFF, 0, "R4 broadcast");
      // R5: eight-bit filtering
      send(8'h5A, 1'b0, 1'b1, 2'd1, 1'b1, 8'h5A, 8'hFF, 0, "R5 match good stop");
      send(8'h5A, 1'b1, 1'b0, 2'd1, 1'b1, 8'h5A, 8'hFF, 0, "R5 match bad stop");
      send(8'h11, 1'b0, 1'b1, 2'd1, 1'b1, 8'h5A, 8'hFF, 0, "R5 no match");
      // R6: masked don't-care bits
      send(8'h52, 1'b1, 1'b1, 2'd2, 1'b1, 8'h5A, 8'hF0, 0, "R6 low nibble ignored");
      send(8'hA2, 1'b1, 1'b1, 2'd2, 1'b1, 8'h5A, 8'hF0, 0, "R6 high nibble differs");
      // R7: broadcast with zero OR matches anything
      send(8'h37, 1'b1, 1'b1, 2'd3, 1'b1, 8'h00, 8'h00, 0, "R7 empty broadcast");
      // R8: back-to-back strobes then gap
      send(8'h5A, 1'b1, 1'b1, 2'd2, 1'b1, 8'h5A, 8'hFF, 1, "R8 burst first");
      send(8'h00, 1'b0, 1'b1, 2'd2, 1'b1, 8'h5A, 8'hFF, 1, "R8 burst second");
      send(8'h5A, 1'b0, 1'b1, 2'd0, 1'b1, 8'h5A, 8'hFF, 0, "R8 burst third");
      // R9: indicators in shift mode and with recognition off
      send(8'h5A, 1'b0, 1'b0, 2'd0, 1'b0, 8'h5A, 8'hFF, 0, "R9 hits in shift mode");

      for (int k = 0; k < 400; k++) begin
         logic [W-1:0] sa, mk, b;
         sa = W'($urandom);
         mk = W'($urandom);
         b  = ($urandom_range(0, 2) == 0) ? (sa | (W'($urandom) & ~mk)) : W'($urandom);
         send(b, 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), sa, mk,
              bit'($urandom_range(0, 1)), "R4/R5/R9 varied frame");
      end
      @(negedge clk);
      frame_done = 1'b0;
      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) check("R8 drained", 3'b111, 3'b000);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule